// File: doc/BRIEF.md
# Fast Infrared Four-Slot PPM Frame Transmitter

This block turns a stream of payload bytes into one complete fast-infrared frame on a single line that drives the optical emitter. The frame has four parts, sent in order. First comes a preamble made of a repeated 16-chip pattern. A start sequence follows. Next come the payload and a 32-bit CRC trailer, both sent as four-slot pulse position symbols. The frame ends with a stop sequence. Each symbol has four chips and carries one bit pair, so one byte takes four symbols. A clock enable at the chip rate paces the line. At a 125 ns chip this gives 4 Mbps.

A frame begins with a one-cycle `frame_go` pulse while the block is idle. The payload port follows valid/ready rules. A byte moves on a cycle where `pay_valid` and `pay_ready` are both high. `pay_last` marks the final payload byte, and at least one byte must be sent. A one-byte holding slot sits behind the port, and `pay_ready` is high only when that slot is empty. The source may hold `pay_valid` low at any time. If no byte is waiting when a new payload byte is due, the line stays low and the frame waits for the next byte. Such a gap breaks the line timing, so a source that cannot keep pace produces a frame that receivers reject. The CRC covers every accepted byte.

Top module: `fir_ppm_tx`

## Requirements
- R1: While reset is active and after it is released, `ir_line`, `frame_busy`, `frame_done` and `pay_ready` are all low.
- R2: A `frame_go` pulse while idle sets `frame_busy` at the next edge. The first chips are the 16-chip word 0x80A8 (most significant bit first), sent 16 times.
- R3: The 32-chip start word 0x03036060 (most significant bit first) directly follows the preamble.
- R4: Each payload byte becomes four symbols, taken from bits [1:0], then [3:2], [5:4] and [7:6]. For a pair value v (bit 1 is the high bit), only chip v of the four chips (0..3, left to right) is high.
- R5: A trailer of 4 bytes follows the last payload byte and is encoded as in R4. Its value is the CRC-32 over the accepted bytes: reflected polynomial 0xEDB88320, start value all ones, LSB-first input, final inversion, sent least significant byte first.
- R6: The 32-chip stop word 0x03030606 follows the trailer. At the next enabled edge, `ir_line` goes low, `frame_busy` goes low and `frame_done` is high for exactly one cycle.
- R7: `ir_line` changes only at clock edges where `chip_en` is high.
- R8: A `frame_go` pulse while `frame_busy` is high has no effect on the chip stream or the frame length.
- R9: `pay_ready` is high only while busy, with the holding slot empty and before the byte marked `pay_last` is taken. Exactly the frame's bytes are accepted.
- R10: While idle, `ir_line` and `pay_ready` stay low, whatever `chip_en` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip-rate enable; one chip per enabled cycle |
| frame_go | input | 1 | Frame start request pulse |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte is valid |
| pay_last | input | 1 | Payload byte is the last of the frame |
| pay_ready | output | 1 | Holding slot can accept a byte |
| ir_line | output | 1 | Modulated line to the optical driver |
| frame_busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at frame end |

## Verification
The checker watches the cycle-level rules on every cycle. It confirms that the line holds steady on cycles without an enable and stays low while idle, that `pay_ready` is high only while busy, that a start while idle raises busy, and that `frame_done` is a single-cycle pulse which clears busy. The exact chip content cannot be seen by a property: the preamble and start/stop words, the bit-pair order, the CRC value and byte order, and the fact that a start during a frame changes nothing. Only the bench's scenarios show these. They compare each recorded chip against a stream built from known CRC vectors, at several enable rates.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam logic [15:0] PRE_WORD  = 16'h80A8;
  localparam logic [31:0] STA_WORD  = 32'h0303_6060;
  localparam logic [31:0] STO_WORD  = 32'h0303_0606;
  localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_STA, ST_PAY, ST_CRC, ST_STO, ST_TAIL
  } tx_state_t;

  typedef enum logic [1:0] {
    SEQ_PRE, SEQ_STA, SEQ_STO
  } seq_sel_t;
endpackage

// File: rtl/fir_fixed_seq.sv
module fir_fixed_seq
  import fir_pkg::*;
(
  input  seq_sel_t   sel,
  input  logic [4:0] idx,
  output logic       chip
);
  logic [3:0] pre_bit;
  logic [4:0] long_bit;

  always_comb begin
    pre_bit  = 4'd15 - idx[3:0];
    long_bit = 5'd31 - idx;
    unique case (sel)
      SEQ_PRE: chip = PRE_WORD[pre_bit];
      SEQ_STA: chip = STA_WORD[long_bit];
      SEQ_STO: chip = STO_WORD[long_bit];
      default: chip = 1'b0;
    endcase
  end
endmodule

// File: rtl/fir_ppm_slot.sv
module fir_ppm_slot #(
  parameter int SLOTS = 4
) (
  input  logic [7:0] octet,
  input  logic [3:0] pos,
  output logic       chip
);
  localparam int PW = $clog2(SLOTS);
  logic [PW-1:0] pair;
  logic [SLOTS-1:0] onehot;

  always_comb begin
    unique case (pos[3:2])
      2'd0: pair = octet[1:0];
      2'd1: pair = octet[3:2];
      2'd2: pair = octet[5:4];
      default: pair = octet[7:6];
    endcase
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign onehot[s] = (pair == PW'(s));
  end

  assign chip = onehot[pos[PW-1:0]];
endmodule

// File: rtl/fir_crc32.sv
module fir_crc32
  import fir_pkg::*;
#(
  parameter logic [31:0] POLY = CRC_POLY,
  parameter logic [31:0] SEED = CRC_SEED
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  octet,
  output logic [31:0] crc_fin
);
  logic [31:0] crc_q, crc_nx;

  always_comb begin
    crc_nx = crc_q;
    for (int i = 0; i < 8; i++) begin
      if (crc_nx[0] ^ octet[i]) crc_nx = (crc_nx >> 1) ^ POLY;
      else                      crc_nx = crc_nx >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= SEED;
    else if (init)  crc_q <= SEED;
    else if (upd)   crc_q <= crc_nx;
  end

  assign crc_fin = ~crc_q;
endmodule

// File: rtl/fir_ppm_tx.sv
module fir_ppm_tx
  import fir_pkg::*;
#(
  parameter int PRE_REPS  = 16,
  parameter int CRC_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_en,
  input  logic       frame_go,
  input  logic [7:0] pay_data,
  input  logic       pay_valid,
  input  logic       pay_last,
  output logic       pay_ready,
  output logic       ir_line,
  output logic       frame_busy,
  output logic       frame_done
);
  localparam int PRE_CHIPS = PRE_REPS * 16;
  localparam int CRC_CHIPS = CRC_BYTES * 16;
  localparam int SEQ_CHIPS = 32;
  localparam int BYTE_CHIPS = 16;
  localparam int CNT_MAX = (PRE_CHIPS > CRC_CHIPS) ? PRE_CHIPS : CRC_CHIPS;
  localparam int CNT_W = $clog2(CNT_MAX);

  tx_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]      hold_q, cur_q;
  logic            hold_v, hold_last, cur_last, got_last;
  logic            accept, underrun;
  logic [31:0]     crc_fin;
  logic            seq_chip, slot_chip, next_chip;
  seq_sel_t        seq_sel;
  logic [7:0]      slot_octet;
  logic [1:0]      crc_idx;

  assign pay_ready = frame_busy && !hold_v && !got_last;
  assign accept    = pay_ready && pay_valid;
  assign underrun  = (state == ST_PAY) && (cnt == '0) && !hold_v;
  assign crc_idx   = cnt[5:4];

  fir_crc32 u_crc (
    .clk(clk), .rst_n(rst_n),
    .init(state == ST_IDLE && frame_go),
    .upd(accept), .octet(pay_data), .crc_fin(crc_fin)
  );

  always_comb begin
    unique case (state)
      ST_STA:  seq_sel = SEQ_STA;
      ST_STO:  seq_sel = SEQ_STO;
      default: seq_sel = SEQ_PRE;
    endcase
  end

  fir_fixed_seq u_seq (.sel(seq_sel), .idx(cnt[4:0]), .chip(seq_chip));

  always_comb begin
    if (state == ST_CRC)   slot_octet = crc_fin[crc_idx*8 +: 8];
    else if (cnt == '0)    slot_octet = hold_q;
    else                   slot_octet = cur_q;
  end

  fir_ppm_slot #(.SLOTS(4)) u_slot (.octet(slot_octet), .pos(cnt[3:0]), .chip(slot_chip));

  always_comb begin
    unique case (state)
      ST_PRE, ST_STA, ST_STO: next_chip = seq_chip;
      ST_PAY:                 next_chip = underrun ? 1'b0 : slot_chip;
      ST_CRC:                 next_chip = slot_chip;
      default:                next_chip = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      hold_q     <= '0;
      hold_v     <= 1'b0;
      hold_last  <= 1'b0;
      cur_q      <= '0;
      cur_last   <= 1'b0;
      got_last   <= 1'b0;
      ir_line    <= 1'b0;
      frame_busy <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (accept) begin
        hold_q    <= pay_data;
        hold_v    <= 1'b1;
        hold_last <= pay_last;
        if (pay_last) got_last <= 1'b1;
      end
      if (state == ST_IDLE) begin
        if (frame_go) begin
          state      <= ST_PRE;
          cnt        <= '0;
          got_last   <= 1'b0;
          frame_busy <= 1'b1;
        end
      end else if (chip_en) begin
        ir_line <= next_chip;
        unique case (state)
          ST_PRE: begin
            if (cnt == CNT_W'(PRE_CHIPS - 1)) begin state <= ST_STA; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          ST_STA: begin
            if (cnt == CNT_W'(SEQ_CHIPS - 1)) begin state <= ST_PAY; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          ST_PAY: begin
            if (!underrun) begin
              if (cnt == '0) begin
                cur_q    <= hold_q;
                cur_last <= hold_last;
                hold_v   <= 1'b0;
              end
              if (cnt == CNT_W'(BYTE_CHIPS - 1)) begin
                cnt <= '0;
                if (cur_last) state <= ST_CRC;
              end else cnt <= cnt + 1'b1;
            end
          end
          ST_CRC: begin
            if (cnt == CNT_W'(CRC_CHIPS - 1)) begin state <= ST_STO; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          ST_STO: begin
            if (cnt == CNT_W'(SEQ_CHIPS - 1)) begin state <= ST_TAIL; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          default: begin
            ir_line    <= 1'b0;
            frame_busy <= 1'b0;
            frame_done <= 1'b1;
            state      <= ST_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fir_ppm_tx_chk.sv
module fir_ppm_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic frame_go,
  input logic pay_ready,
  input logic ir_line,
  input logic frame_busy,
  input logic frame_done
);
  a_r7_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(ir_line));
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_busy |-> !ir_line);
  a_r9_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> frame_busy);
  a_r2_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && !frame_busy) |=> frame_busy);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!frame_busy && $past(frame_busy)));
endmodule

bind fir_ppm_tx fir_ppm_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .frame_go(frame_go),
  .pay_ready(pay_ready), .ir_line(ir_line), .frame_busy(frame_busy),
  .frame_done(frame_done)
);

// File: tb/sim_fir_ppm_tx.sv
module sim_fir_ppm_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_en = 1'b0, frame_go = 1'b0;
  logic [7:0] pay_data = '0;
  logic pay_valid = 1'b0, pay_last = 1'b0;
  logic pay_ready, ir_line, frame_busy, frame_done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fir_ppm_tx u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .frame_go(frame_go),
    .pay_data(pay_data), .pay_valid(pay_valid), .pay_last(pay_last),
    .pay_ready(pay_ready), .ir_line(ir_line), .frame_busy(frame_busy),
    .frame_done(frame_done)
  );

  // {len[3:0], data[71:0] byte0 low, crc[31:0], div[1:0], poke}
  localparam int NV = 4;
  localparam logic [110:0] VEC [NV] = '{
    {4'd1, 72'h00,                 32'hD202EF8D, 2'd1, 1'b0},
    {4'd1, 72'h61,                 32'hE8B7BE43, 2'd2, 1'b1},
    {4'd3, 72'h636261,             32'h352441C2, 2'd3, 1'b0},
    {4'd9, 72'h393837363534333231, 32'hCBF43926, 2'd1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_chip(input int i, input int len,
                                  input logic [71:0] d, input logic [31:0] c);
    int k, b, pr, sl;
    logic [7:0] oc;
    if (i < 256) return 1'((16'h80A8 >> (15 - i % 16)) & 1);
    if (i < 288) return 1'((32'h03036060 >> (31 - (i - 256))) & 1);
    k = i - 288;
    if (k < 16 * (len + 4)) begin
      b = k / 16; pr = (k % 16) / 4; sl = k % 4;
      oc = (b < len) ? d[b*8 +: 8] : c[(b-len)*8 +: 8];
      return ((oc >> (2 * pr)) & 8'd3) == 8'(sl);
    end
    k = k - 16 * (len + 4);
    return 1'((32'h03030606 >> (31 - k)) & 1);
  endfunction

  task automatic run_frame(input int len, input logic [71:0] d,
                           input logic [31:0] c, input int div, input bit poke);
    int n = 0, sent = 0, gate_bad = 0, dones = 0;
    int mis[5] = '{0, 0, 0, 0, 0};
    int exp_n = 256 + 32 + 16 * (len + 4) + 32;
    bit prev_en = 0, fired = 0, fin = 0, last_tx = 0;
    @(negedge clk);
    frame_go = 1'b1; chip_en = 1'b0;
    @(negedge clk);
    frame_go = 1'b0;
    check(frame_busy === 1'b1, "R2", "busy after go", int'(frame_busy), 1);
    last_tx = ir_line;
    for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (fired) sent++;
      if (frame_done) begin
        fin = 1; dones++;
      end else if (prev_en) begin
        if (ir_line !== exp_chip(n, len, d, c)) begin
          if (n < 256) mis[0]++;
          else if (n < 288) mis[1]++;
          else if (n < 288 + 16 * len) mis[2]++;
          else if (n < 288 + 16 * (len + 4)) mis[3]++;
          else mis[4]++;
        end
        n++;
      end else if (ir_line !== last_tx) gate_bad++;
      last_tx = ir_line;
      chip_en   = (cyc % div) == 0;
      frame_go  = poke && (n == 100);
      pay_valid = sent < len;
      pay_data  = (sent < len) ? d[sent*8 +: 8] : 8'h00;
      pay_last  = (sent == len - 1);
      fired     = pay_valid && pay_ready;
      prev_en   = chip_en;
    end
    frame_go = 1'b0; pay_valid = 1'b0; pay_last = 1'b0; chip_en = 1'b0;
    check(mis[0] == 0, "R2", "preamble chip errors", mis[0], 0);
    check(mis[1] == 0, "R3", "start word chip errors", mis[1], 0);
    check(mis[2] == 0, "R4", "payload chip errors", mis[2], 0);
    check(mis[3] == 0, "R5", "crc trailer chip errors", mis[3], 0);
    check(mis[4] == 0, "R6", "stop word chip errors", mis[4], 0);
    check(n == exp_n, poke ? "R8" : "R6", "chip count", n, exp_n);
    check(gate_bad == 0, "R7", "changes without enable", gate_bad, 0);
    check(sent == len, "R9", "bytes accepted", sent, len);
    check(frame_busy === 1'b0 && ir_line === 1'b0, "R6", "busy/line at done",
          int'({frame_busy, ir_line}), 0);
    @(negedge clk);
    check(frame_done === 1'b0 && dones == 1, "R6", "done pulse width",
          int'(frame_done) + dones, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({ir_line, frame_busy, frame_done, pay_ready} === 4'b0, "R1",
          "outputs in reset", int'({ir_line, frame_busy, frame_done, pay_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({ir_line, frame_busy, frame_done, pay_ready} === 4'b0, "R1",
          "outputs after reset", int'({ir_line, frame_busy, frame_done, pay_ready}), 0);
    for (int v = 0; v < NV; v++) begin
      run_frame(int'(VEC[v][110:107]), VEC[v][106:35], VEC[v][34:3],
                int'(VEC[v][2:1]), VEC[v][0]);
    end
    // R10: idle with the enable toggling and a valid source
    begin
      int moved = 0;
      pay_valid = 1'b1; pay_data = 8'hA5;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        chip_en = i[0];
        if (ir_line !== 1'b0 || pay_ready !== 1'b0 || frame_busy !== 1'b0) moved++;
      end
      pay_valid = 1'b0; chip_en = 1'b0;
      check(moved == 0, "R10", "idle activity", moved, 0);
    end
    // R1: reset in the middle of a frame
    @(negedge clk); frame_go = 1'b1; chip_en = 1'b1;
    @(negedge clk); frame_go = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({ir_line, frame_busy, frame_done, pay_ready} === 4'b0, "R1",
          "mid-frame reset", int'({ir_line, frame_busy, frame_done, pay_ready}), 0);
    rst_n = 1'b1; chip_en = 1'b0;
    @(negedge clk);
    run_frame(1, 72'h61, 32'hE8B7BE43, 1, 1'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule